// File: doc/BRIEF.md
# Page-Mode ROM Wait Controller

This block sits beside the bus controller in front of a ROM that supports page-mode reads. It decides how many wait states each ROM read takes. It keeps the address of the last accepted ROM cycle. When a new cycle starts, it compares the address bits above the configured page boundary with the same bits of the stored address.

If those bits match, the device is still on the open page and the short page wait count applies. If they differ, or if no valid previous ROM cycle exists, the long normal wait count applies. The controller then raises ready after exactly that many wait cycles. A page-hit flag reports which count was chosen.

The bus controller signals any bus cycle that does not go to the ROM on a separate input. Such a cycle invalidates the stored address, so the next ROM cycle pays the full access time. The page width is chosen at run time from five power-of-two sizes. The ROM data path and chip-select decoding are not part of this block.

Top module: `pgrom_wait_ctl`

## Requirements
- R1: After reset, `ready` and `page_hit` are low, and the first ROM cycle is treated as off-page.
- R2: A ROM cycle is on-page only when a valid previous ROM cycle exists and every address bit at or above log2(page width) equals the stored address. Bits below that position are ignored.
- R3: `page_sel` selects the page width: code 0 is 8 bytes, 1 is 16, 2 is 32, 3 is 64 and 4 is 128. Codes 5, 6 and 7 behave as 128 bytes.
- R4: An on-page cycle uses `wait_on` as its wait count. An off-page cycle uses `wait_off`.
- R5: A ROM cycle is accepted when `cyc_start` is high while the block is idle; call that cycle T. With a selected count N, `ready` is high only in cycle T+N and low in cycles T+1 to T+N-1. When N is zero, `ready` is high in cycle T itself, combinationally.
- R6: `page_hit` shows the comparison result from cycle T onward and holds it until the next accepted ROM cycle.
- R7: If `other_cyc` is high in a cycle with no accepted ROM cycle, the stored address is invalidated. The next ROM cycle is then off-page.
- R8: `cyc_start` while a cycle is still waiting is ignored. It changes neither the ready timing nor the stored address.
- R9: If `cyc_start` is accepted in the same cycle as `other_cyc`, the ROM cycle wins. Its address is stored as valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | Start of a ROM read cycle |
| other_cyc | input | 1 | Start of a bus cycle to a non-ROM target |
| addr | input | AW (32) | Byte address of the ROM cycle |
| page_sel | input | 3 | Page width code |
| wait_on | input | WW (4) | Wait states for an on-page cycle |
| wait_off | input | WW (4) | Wait states for an off-page cycle |
| ready | output | 1 | Cycle completes in this clock |
| page_hit | output | 1 | Current or last ROM cycle was on-page |

## Verification
Two pairs of functions can land in the same clock, and the bench drives both on purpose.

The first pair is a ROM start and an invalidating non-ROM cycle. The bench raises `other_cyc` together with an accepted `cyc_start`, then issues a same-page address. It expects a hit and the short wait, because the ROM cycle must win.

The second pair is a new start and a wait still in progress. The bench repeats `cyc_start` with a far-away address during the wait. It checks that ready still lands on the original count and that the following cycle still compares against the first address.

// File: rtl/pgrom_pkg.sv
package pgrom_pkg;
    // Smallest page is 2**PG_MIN_LOG2 bytes; PG_CODES sizes in total.
    localparam int PG_MIN_LOG2 = 3;
    localparam int PG_CODES    = 5;
    localparam int PG_SEL_W    = 3;

    function automatic int unsigned code_index(input logic [PG_SEL_W-1:0] sel);
        if (int'(sel) >= PG_CODES) return PG_CODES - 1;
        return int'(sel);
    endfunction
endpackage

// File: rtl/pgrom_page_cmp.sv
module pgrom_page_cmp
    import pgrom_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0]       addr_new,
    input  logic [AW-1:0]       addr_old,
    input  logic [PG_SEL_W-1:0] sel,
    output logic                same_page
);
    localparam int TOP_LOG2 = PG_MIN_LOG2 + PG_CODES - 1;

    logic [AW-1:0]       diff;
    logic [PG_CODES-1:0] match;

    assign diff = addr_new ^ addr_old;

    // One comparator per page size; only bits at or above the boundary count.
    for (genvar g = 0; g < PG_CODES; g++) begin : g_size
        localparam int SH = PG_MIN_LOG2 + g;
        assign match[g] = (diff[AW-1:SH] == '0);
    end

    always_comb begin
        same_page = match[code_index(sel)];
    end

    if (AW <= TOP_LOG2) begin : g_bad_aw
        initial $fatal(1, "address too narrow for largest page");
    end
endmodule

// File: rtl/pgrom_wait_cnt.sv
module pgrom_wait_cnt #(
    parameter int WW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [WW-1:0] load_val,
    output logic          busy,
    output logic          expire
);
    typedef struct packed {
        logic          busy;
        logic [WW-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load && (load_val != '0)) begin
            st_d.busy = 1'b1;
            st_d.cnt  = load_val - 1'b1;
        end else if (st_q.busy) begin
            if (st_q.cnt == '0) st_d.busy = 1'b0;
            else                st_d.cnt  = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy   = st_q.busy;
    assign expire = st_q.busy && (st_q.cnt == '0);
endmodule

// File: rtl/pgrom_wait_ctl.sv
module pgrom_wait_ctl
    import pgrom_pkg::*;
#(
    parameter int AW = 32,
    parameter int WW = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cyc_start,
    input  logic                other_cyc,
    input  logic [AW-1:0]       addr,
    input  logic [PG_SEL_W-1:0] page_sel,
    input  logic [WW-1:0]       wait_on,
    input  logic [WW-1:0]       wait_off,
    output logic                ready,
    output logic                page_hit
);
    typedef struct packed {
        logic [AW-1:0] last_addr;
        logic          valid;
        logic          hit;
    } ctl_st_t;

    ctl_st_t       st_d, st_q;
    logic          busy_q;
    logic          expire;
    logic          accept;
    logic          same_page;
    logic          hit_now;
    logic [WW-1:0] sel_wait;

    pgrom_page_cmp #(.AW(AW)) u_cmp (
        .addr_new (addr),
        .addr_old (st_q.last_addr),
        .sel      (page_sel),
        .same_page(same_page)
    );

    always_comb begin
        accept   = cyc_start && !busy_q;
        hit_now  = st_q.valid && same_page;
        sel_wait = hit_now ? wait_on : wait_off;

        st_d = st_q;
        if (accept) begin
            st_d.last_addr = addr;
            st_d.valid     = 1'b1;
            st_d.hit       = hit_now;
        end else if (other_cyc) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    pgrom_wait_cnt #(.WW(WW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .load_val(sel_wait),
        .busy    (busy_q),
        .expire  (expire)
    );

    assign ready    = (accept && (sel_wait == '0)) || expire;
    assign page_hit = accept ? hit_now : st_q.hit;
endmodule

// File: rtl/pgrom_wait_chk.sv
module pgrom_wait_chk #(
    parameter int AW = 32,
    parameter int WW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cyc_start,
    input logic          other_cyc,
    input logic [WW-1:0] wait_on,
    input logic [WW-1:0] wait_off,
    input logic          ready,
    input logic          page_hit,
    input logic          busy,
    input logic [AW-1:0] last_addr
);
    a_r1_quiet_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (busy || cyc_start));

    a_r5_zero_on: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && !busy && page_hit && wait_on == '0) |-> ready);

    a_r4_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && !busy && !page_hit && wait_off == '0) |-> ready);

    a_r5_no_early: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && !busy && page_hit && wait_on > 1) |=> !ready);

    a_r5_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && busy) |=> !busy);

    a_r6_hit_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy -> $stable(page_hit)));

    a_r8_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(last_addr));

    a_r7_invalidate: assert property (@(posedge clk) disable iff (!rst_n)
        (other_cyc && !cyc_start && !busy) ##1 (cyc_start && !busy) |-> !page_hit);
endmodule

bind pgrom_wait_ctl pgrom_wait_chk #(.AW(AW), .WW(WW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_start(cyc_start),
    .other_cyc(other_cyc),
    .wait_on  (wait_on),
    .wait_off (wait_off),
    .ready    (ready),
    .page_hit (page_hit),
    .busy     (busy_q),
    .last_addr(st_q.last_addr)
);

// File: tb/sim_pgrom_wait_ctl.sv
module sim_pgrom_wait_ctl;
    localparam int AW = 32;
    localparam int WW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cyc_start = 1'b0;
    logic          other_cyc = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [2:0]    page_sel = '0;
    logic [WW-1:0] wait_on = '0;
    logic [WW-1:0] wait_off = '0;
    logic          ready;
    logic          page_hit;

    int n_vec = 0;
    int n_bad = 0;
    logic [AW-1:0] m_last = '0;
    bit            m_valid = 1'b0;

    always #4 clk = ~clk;

    pgrom_wait_ctl #(.AW(AW), .WW(WW)) u0 (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .other_cyc(other_cyc),
        .addr(addr), .page_sel(page_sel), .wait_on(wait_on), .wait_off(wait_off),
        .ready(ready), .page_hit(page_hit)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int shift_of(input logic [2:0] s);
        return 3 + ((s > 3'd4) ? 4 : int'(s));
    endfunction

    function automatic bit model_hit(input logic [AW-1:0] a, input logic [2:0] s);
        return m_valid && (((a ^ m_last) >> shift_of(s)) == 0);
    endfunction

    // One ROM cycle. Inputs change on the falling edge; outputs are read 1 ns later.
    // extra_start re-asserts cyc_start during the wait with a far address (R8).
    // with_other raises other_cyc together with the start (R9).
    task automatic rom_cycle(input logic [AW-1:0] a, input logic [2:0] s,
                             input int won, input int woff,
                             input bit extra_start, input bit with_other);
        bit hit;
        int n;
        hit = model_hit(a, s);
        n = hit ? won : woff;
        @(negedge clk);
        addr = a; page_sel = s;
        wait_on = WW'(won); wait_off = WW'(woff);
        cyc_start = 1'b1; other_cyc = with_other;
        #1;
        chk(hit ? "R2 R4 hit" : "R2 R4 miss", page_hit, hit);
        chk("R5 start-cycle ready", ready, n == 0);
        m_last = a; m_valid = 1'b1;
        for (int k = 1; k <= n + 1; k++) begin
            @(negedge clk);
            other_cyc = 1'b0;
            cyc_start = extra_start && (k < n);
            if (cyc_start) addr = ~a;
            #1;
            chk("R5 R8 ready timing", ready, k == n);
            chk("R6 hit held", page_hit, hit);
        end
        cyc_start = 1'b0;
    endtask

    initial begin : wd
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset ready", ready, 1'b0);
        chk("R1 reset hit", page_hit, 1'b0);
        rst_n = 1'b1;

        // R1: the first cycle after reset is off-page, even at address zero.
        rom_cycle(32'h0, 3'd0, 1, 3, 0, 0);

        // R3 R2: sweep every width code, wait pair and offset pattern.
        for (int s = 0; s < 8; s++)
            for (int won = 0; won < 4; won++)
                for (int woff = 0; woff < 4; woff++) begin
                    int sh;
                    logic [AW-1:0] base;
                    sh = shift_of(3'(s));
                    base = 32'h0001_0000 + (AW'(won * 4 + woff) << 8);
                    rom_cycle(base, 3'(s), won, woff, 0, 0);
                    rom_cycle(base | ((AW'(1) << sh) - 1), 3'(s), won, woff, 0, 0);
                    rom_cycle(base ^ (AW'(1) << sh), 3'(s), won, woff, 0, 0);
                    rom_cycle(base ^ (AW'(1) << (sh - 1)), 3'(s), won, woff, 0, 0);
                end

        // R7: an idle non-ROM cycle forces the next ROM cycle off-page.
        rom_cycle(32'h2000, 3'd2, 1, 2, 0, 0);
        @(negedge clk); other_cyc = 1'b1;
        @(negedge clk); other_cyc = 1'b0;
        m_valid = 1'b0;
        rom_cycle(32'h2004, 3'd2, 1, 2, 0, 0);

        // R9: a start together with other_cyc keeps the address valid.
        rom_cycle(32'h3000, 3'd1, 2, 3, 0, 1);
        rom_cycle(32'h3008, 3'd1, 2, 3, 0, 0);

        // R8: starts during the wait are ignored; the next cycle still compares
        // against the first address.
        rom_cycle(32'h5000, 3'd4, 1, 4, 1, 0);
        rom_cycle(32'h5010, 3'd4, 1, 4, 1, 0);
        rom_cycle(32'h9000, 3'd0, 0, 3, 1, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule